// File: doc/BRIEF.md
# Ferroelectric Cell Access Sequencer

This block turns word-level read and write requests into timed control strobes for an array of one-transistor, one-capacitor ferroelectric cells. A host presents a request with an address, write data and a write flag. The block latches the request, decodes the address into a single wordline and then runs a fixed sequence of phases. Each phase drives a set of row and column strobes for a number of clock cycles set by a parameter.

A write drives each column's bitline and plateline to opposite levels, and the pair of levels encodes the bit. Once the drive phase ends, the wordline drops a cycle before the column drivers release. A read has more phases. It precharges the bitlines low and then opens the wordline. It pulses all platelines high and enables the sense amplifiers, which resolve each bitline. The plate pulse destroys the stored value, so the read then restores the sensed word into the row. The wordline stays open until the bitlines have been precharged low again. Read data is returned only after this restore.

Each column has its own plateline, so a single write can store a word that mixes ones and zeros. The sense amplifiers report one resolved bit per column on `sense_i`.

Top module: `fecell_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, `ready_o` and `pre_o` are 1, and `wl_o`, `bl_drv_en_o`, `sa_en_o`, `pl_o`, `bl_lvl_o` and `rvalid_o` are all 0.
- R2: A write holds the addressed wordline and `bl_drv_en_o` high for `T_WDRV` cycles. For every column, `pl_o` equals the write bit and `bl_lvl_o` equals its inverse: a 1 raises the plateline with the bitline low, and a 0 raises the bitline with the plateline low.
- R3: After the write drive phase there is exactly one cycle with the wordline low while `bl_drv_en_o`, `bl_lvl_o` and `pl_o` keep their drive values. The block is idle the cycle after that.
- R4: A read starts with `T_PRE` cycles of `pre_o` high and all wordlines low. Then come `T_WLS` cycles with the wordline high and `pre_o`, the platelines and sensing all off.
- R5: Next, all platelines are high for `T_PLATE` cycles with sensing off. Then come `T_SENSE` cycles with the platelines still high and `sa_en_o` high.
- R6: A restore phase follows for `T_REST` cycles. In it `sa_en_o` is high, the column drivers are off, and each plateline equals the bit sensed on its column, so the cells hold the read word again afterwards.
- R7: After restore, the wordline stays high for `T_PREB` cycles with `pre_o` high and all other strobes off. Only then does it drop.
- R8: `rvalid_o` pulses for one cycle, in the first idle cycle after a read, with `rdata_o` equal to the sensed word. A second read of the same row returns the same word. `rvalid_o` is 0 at all other times.
- R9: `ready_o` is 1 exactly when no sequence is running. A request made while `ready_o` is 0 is ignored: the running sequence completes unchanged and no new sequence follows from it.
- R10: `bl_drv_en_o` and `sa_en_o` are never both 1.
- R11: At most one wordline is high, and it is bit `addr` of `wl_o` for the address latched with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request; taken when `ready_o` is 1 |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Row address |
| wdata_i | input | DATA_W | Word to write |
| sense_i | input | DATA_W | Resolved sense-amplifier bit per column |
| ready_o | output | 1 | Idle, able to take a request |
| rvalid_o | output | 1 | One-cycle pulse: `rdata_o` holds a completed read |
| rdata_o | output | DATA_W | Word from the last read |
| wl_o | output | 2**ADDR_W | One-hot wordline enables |
| pre_o | output | 1 | Bitline precharge to low |
| bl_drv_en_o | output | 1 | Column bitline drivers on |
| bl_lvl_o | output | DATA_W | Level driven on each bitline |
| pl_o | output | DATA_W | Plateline drive per column |
| sa_en_o | output | 1 | Sense-amplifier enable |

## Verification
Writes use mixed, all-zero and all-one words, so an inverted or swapped bitline/plateline pair shows up on specific columns. They target the lowest and highest rows and one row in between to expose decode errors. Each row is read twice in a row: a missing or wrong restore leaves the behavioural cells at all ones and changes the second result, while a correct restore returns the same word. Reads and writes are also issued while the host keeps `req_i` high with garbage fields through the whole sequence, and back-to-back in the cycle of the read-data pulse. This separates a sequence that ignores requests while busy from one that restarts or latches the wrong fields.

// File: rtl/fecell_pkg.sv
`timescale 1ns/1ps
// Shared types for the ferroelectric cell access sequencer.
package fecell_pkg;

    // Sequencer phases; write and read paths share only the idle state.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WDRV,
        ST_WREL,
        ST_RPRE,
        ST_RWL,
        ST_RPLATE,
        ST_RSENSE,
        ST_RREST,
        ST_RPREB
    } seq_state_t;

endpackage

// File: rtl/fecell_phase_timer.sv
`timescale 1ns/1ps
// Phase down-counter.
// Loads (length - 1) on phase entry and flags the last cycle of a phase.
// Assumes the load value fits CNT_W bits.
module fecell_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    // Count down to zero, reload on a phase change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);
endmodule

// File: rtl/fecell_row_dec.sv
`timescale 1ns/1ps
// Address to one-hot row decoder.
// Assumes ROWS == 2**ADDR_W.
module fecell_row_dec #(
    parameter int ADDR_W = 4,
    parameter int ROWS   = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROWS-1:0]   row_sel
);
    // One comparator per row.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_sel[r] = (addr == ADDR_W'(r));
    end
endmodule

// File: rtl/fecell_strobe_gen.sv
`timescale 1ns/1ps
// Strobe decoder: maps the current phase to the array control strobes.
// Purely combinational; assumes row_sel is one-hot or zero.
module fecell_strobe_gen
    import fecell_pkg::*;
#(
    parameter int ROWS   = 16,
    parameter int DATA_W = 8
) (
    input  seq_state_t        state,
    input  logic [ROWS-1:0]   row_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] sensed,
    output logic [ROWS-1:0]   wl,
    output logic              pre,
    output logic              drv_en,
    output logic [DATA_W-1:0] bl_lvl,
    output logic [DATA_W-1:0] pl,
    output logic              sa_en
);
    // Per-phase strobe table.
    always_comb begin
        wl     = '0;
        pre    = 1'b0;
        drv_en = 1'b0;
        bl_lvl = '0;
        pl     = '0;
        sa_en  = 1'b0;
        unique case (state)
            ST_IDLE: pre = 1'b1;
            ST_WDRV: begin
                wl     = row_sel;
                drv_en = 1'b1;
                bl_lvl = ~wdata;
                pl     = wdata;
            end
            ST_WREL: begin
                drv_en = 1'b1;
                bl_lvl = ~wdata;
                pl     = wdata;
            end
            ST_RPRE: pre = 1'b1;
            ST_RWL:  wl  = row_sel;
            ST_RPLATE: begin
                wl = row_sel;
                pl = '1;
            end
            ST_RSENSE: begin
                wl    = row_sel;
                pl    = '1;
                sa_en = 1'b1;
            end
            ST_RREST: begin
                wl    = row_sel;
                pl    = sensed;
                sa_en = 1'b1;
            end
            ST_RPREB: begin
                wl  = row_sel;
                pre = 1'b1;
            end
            default: pre = 1'b1;
        endcase
    end
endmodule

// File: rtl/fecell_seq.sv
`timescale 1ns/1ps
// Ferroelectric cell access sequencer (top).
// Takes one read or write request at a time and sequences the array strobes.
// A read is destructive and always ends with a restore and a bitline
// precharge before the wordline drops. Assumes every phase length is >= 1.
module fecell_seq
    import fecell_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int T_WDRV  = 3,
    parameter int T_PRE   = 2,
    parameter int T_WLS   = 1,
    parameter int T_PLATE = 2,
    parameter int T_SENSE = 2,
    parameter int T_REST  = 2,
    parameter int T_PREB  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic                   we_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [DATA_W-1:0]      wdata_i,
    input  logic [DATA_W-1:0]      sense_i,
    output logic                   ready_o,
    output logic                   rvalid_o,
    output logic [DATA_W-1:0]      rdata_o,
    output logic [(1<<ADDR_W)-1:0] wl_o,
    output logic                   pre_o,
    output logic                   bl_drv_en_o,
    output logic [DATA_W-1:0]      bl_lvl_o,
    output logic [DATA_W-1:0]      pl_o,
    output logic                   sa_en_o
);
    localparam int ROWS  = 1 << ADDR_W;
    localparam int MAX_A = (T_WDRV  > T_PRE)  ? T_WDRV  : T_PRE;
    localparam int MAX_B = (T_WLS   > T_PLATE) ? T_WLS  : T_PLATE;
    localparam int MAX_C = (T_SENSE > T_REST) ? T_SENSE : T_REST;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_E = (MAX_C > T_PREB) ? MAX_C : T_PREB;
    localparam int MAX_T = (MAX_D > MAX_E) ? MAX_D : MAX_E;
    localparam int CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);

    seq_state_t        state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] sensed_q;
    logic [ROWS-1:0]   row_sel;
    logic              ph_last;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;

    // Length minus one of each phase, as loaded into the timer.
    function automatic logic [CNT_W-1:0] phase_len(input seq_state_t s);
        int n;
        unique case (s)
            ST_WDRV:   n = T_WDRV;
            ST_RPRE:   n = T_PRE;
            ST_RWL:    n = T_WLS;
            ST_RPLATE: n = T_PLATE;
            ST_RSENSE: n = T_SENSE;
            ST_RREST:  n = T_REST;
            ST_RPREB:  n = T_PREB;
            default:   n = 1;
        endcase
        return CNT_W'(n - 1);
    endfunction

    // Successor of each phase once it has run its length.
    function automatic seq_state_t succ(input seq_state_t s);
        unique case (s)
            ST_WDRV:   return ST_WREL;
            ST_RPRE:   return ST_RWL;
            ST_RWL:    return ST_RPLATE;
            ST_RPLATE: return ST_RSENSE;
            ST_RSENSE: return ST_RREST;
            ST_RREST:  return ST_RPREB;
            default:   return ST_IDLE;
        endcase
    endfunction

    // Next-phase selection and timer reload.
    always_comb begin
        nxt = state;
        if (state == ST_IDLE) begin
            if (req_i)
                nxt = we_i ? ST_WDRV : ST_RPRE;
        end else if (ph_last) begin
            nxt = succ(state);
        end
        ld     = (nxt != state);
        ld_val = phase_len(nxt);
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state == ST_IDLE && req_i) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    // Sensed word capture at the end of the sense phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sensed_q <= '0;
        else if (state == ST_RSENSE && ph_last)
            sensed_q <= sense_i;
    end

    // Read return, published as the wordline closes after restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
        end else begin
            rvalid_o <= (state == ST_RPREB) && ph_last;
            if (state == ST_RPREB && ph_last)
                rdata_o <= sensed_q;
        end
    end

    assign ready_o = (state == ST_IDLE);

    fecell_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .last     (ph_last)
    );

    fecell_row_dec #(.ADDR_W(ADDR_W), .ROWS(ROWS)) dec_i (
        .addr    (addr_q),
        .row_sel (row_sel)
    );

    fecell_strobe_gen #(.ROWS(ROWS), .DATA_W(DATA_W)) strobe_i (
        .state   (state),
        .row_sel (row_sel),
        .wdata   (wdata_q),
        .sensed  (sensed_q),
        .wl      (wl_o),
        .pre     (pre_o),
        .drv_en  (bl_drv_en_o),
        .bl_lvl  (bl_lvl_o),
        .pl      (pl_o),
        .sa_en   (sa_en_o)
    );
endmodule

// File: rtl/fecell_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for fecell_seq, attached by bind.
// Observes ports only; assumes synchronous active-low reset.
module fecell_seq_chk #(
    parameter int ROWS   = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              ready_o,
    input logic              rvalid_o,
    input logic [ROWS-1:0]   wl_o,
    input logic              pre_o,
    input logic              bl_drv_en_o,
    input logic [DATA_W-1:0] pl_o,
    input logic              sa_en_o
);
    logic wl_any;
    assign wl_any = |wl_o;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (ready_o && pre_o && !wl_any && !bl_drv_en_o && !sa_en_o && pl_o == '0));

    // R10
    drive_sense_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bl_drv_en_o && sa_en_o));

    // R11
    single_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wl_o));

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && req_i) |=> !ready_o);

    // R3
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wl_any) && $past(bl_drv_en_o)) |-> bl_drv_en_o);

    // R7
    read_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wl_any) && !$past(bl_drv_en_o)) |-> $past(pre_o));

    // R4
    read_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wl_any) && !bl_drv_en_o) |-> ($past(pre_o) && !pre_o));

    // R5
    sense_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sa_en_o) |-> ((&pl_o) && wl_any));

    // R8
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (ready_o && !wl_any));
endmodule

bind fecell_seq fecell_seq_chk #(.ROWS(ROWS), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .ready_o     (ready_o),
    .rvalid_o    (rvalid_o),
    .wl_o        (wl_o),
    .pre_o       (pre_o),
    .bl_drv_en_o (bl_drv_en_o),
    .pl_o        (pl_o),
    .sa_en_o     (sa_en_o)
);

// File: tb/fecell_seq_tb_top.sv
`timescale 1ns/1ps
module fecell_seq_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NR = 1 << AW;
    localparam int P_WDRV = 3, P_PRE = 2, P_WLS = 1, P_PLATE = 2;
    localparam int P_SENSE = 2, P_REST = 2, P_PREB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0, we_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] sense_i;
    logic          ready_o, rvalid_o, pre_o, bl_drv_en_o, sa_en_o;
    logic [DW-1:0] rdata_o, bl_lvl_o, pl_o;
    logic [NR-1:0] wl_o;

    always #10 clk = ~clk;

    fecell_seq #(.ADDR_W(AW), .DATA_W(DW), .T_WDRV(P_WDRV), .T_PRE(P_PRE),
                 .T_WLS(P_WLS), .T_PLATE(P_PLATE), .T_SENSE(P_SENSE),
                 .T_REST(P_REST), .T_PREB(P_PREB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .sense_i(sense_i), .ready_o(ready_o),
        .rvalid_o(rvalid_o), .rdata_o(rdata_o), .wl_o(wl_o), .pre_o(pre_o),
        .bl_drv_en_o(bl_drv_en_o), .bl_lvl_o(bl_lvl_o), .pl_o(pl_o),
        .sa_en_o(sa_en_o));

    // Behavioural cell array standing in for the analog rows.
    logic [DW-1:0] cells [NR];
    logic [DW-1:0] snap = '0;
    logic          snapped = 1'b0;
    assign sense_i = sa_en_o ? snap : '0;

    initial for (int i = 0; i < NR; i++) cells[i] = '0;

    always @(posedge clk) begin
        if (wl_o == '0) snapped <= 1'b0;
        for (int r = 0; r < NR; r++) begin
            if (wl_o[r]) begin
                if (bl_drv_en_o)
                    cells[r] <= (cells[r] & ~(pl_o ^ bl_lvl_o)) | (pl_o & ~bl_lvl_o);
                else if (sa_en_o)
                    cells[r] <= pl_o;
                else if ((&pl_o) && !snapped) begin
                    snap     <= cells[r];
                    cells[r] <= '1;
                    snapped  <= 1'b1;
                end
            end
        end
    end

    // Reference model: a queue of expected per-cycle strobes.
    typedef struct packed {
        logic          wl;
        logic          pre;
        logic          drv;
        logic          sa;
        logic [DW-1:0] bl;
        logic [DW-1:0] pl;
        logic [AW-1:0] row;
        logic          last_rd;
        logic [DW-1:0] rd;
        logic [3:0]    tag;
    } exp_t;

    exp_t          q[$];
    logic [DW-1:0] ref_mem [NR];
    int            n_chk = 0, n_fail = 0;
    bit            rv_due = 0;
    logic [DW-1:0] rv_data = '0;
    bit            done = 0;

    initial for (int i = 0; i < NR; i++) ref_mem[i] = '0;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_n(input int n, input exp_t e);
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    task automatic accept(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_t e;
        logic [DW-1:0] v;
        e = '0;
        e.row = a;
        if (w) begin
            // R2: drive phase; R3: release cycle
            e.wl = 1; e.drv = 1; e.bl = ~d; e.pl = d; e.tag = 2;
            push_n(P_WDRV, e);
            e.wl = 0; e.tag = 3;
            push_n(1, e);
            ref_mem[a] = d;
        end else begin
            v = ref_mem[a];
            e.pre = 1; e.tag = 4;                          // R4
            push_n(P_PRE, e);
            e = '0; e.row = a; e.wl = 1; e.tag = 4;
            push_n(P_WLS, e);
            e.pl = '1; e.tag = 5;                          // R5
            push_n(P_PLATE, e);
            e.sa = 1;
            push_n(P_SENSE, e);
            e.pl = v; e.tag = 6;                           // R6
            push_n(P_REST, e);
            e.sa = 0; e.pl = '0; e.pre = 1; e.tag = 7;     // R7
            push_n(P_PREB - 1, e);
            e.last_rd = 1; e.rd = v;
            push_n(1, e);
        end
    endtask

    // One clock: compare at the falling edge, then set inputs for the next edge.
    task automatic cyc(input logic rq, input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        exp_t e;
        bit   idle;
        logic [NR-1:0] ewl;
        @(negedge clk);
        // R8: read return pulse and data
        if (rv_due)
            check(rvalid_o === 1'b1 && rdata_o === rv_data, "R8 read return",
                  {rvalid_o, rdata_o}, {1'b1, rv_data});
        else
            check(rvalid_o === 1'b0, "R8 no stray pulse", rvalid_o, 0);
        rv_due = 0;
        idle = (q.size() == 0);
        if (idle) begin
            e = '0; e.pre = 1; e.tag = 1;
        end else begin
            e = q.pop_front();
            if (e.last_rd) begin rv_due = 1; rv_data = e.rd; end
        end
        // R9: ready exactly when idle
        check(ready_o === idle, "R9 ready", ready_o, idle);
        // R11: wordline is bit <row>
        ewl = e.wl ? (NR'(1) << e.row) : '0;
        check({wl_o, pre_o, bl_drv_en_o, sa_en_o, bl_lvl_o, pl_o} ===
              {ewl, e.pre, e.drv, e.sa, e.bl, e.pl},
              $sformatf("R%0d/R11 strobes", e.tag),
              {wl_o, pre_o, bl_drv_en_o, sa_en_o, bl_lvl_o, pl_o},
              {ewl, e.pre, e.drv, e.sa, e.bl, e.pl});
        req_i = rq; we_i = w; addr_i = a; wdata_i = d;
        if (rq && idle) accept(w, a, d);
    endtask

    // Full operation; optionally keeps a garbage request up while busy (R9).
    task automatic op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit noise);
        cyc(1'b1, w, a, d);
        while (q.size() > 0) cyc(noise, ~w, ~a, ~d);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: strobes while in reset
        check(ready_o === 1 && pre_o === 1 && wl_o === '0 && !bl_drv_en_o &&
              !sa_en_o && pl_o === '0 && bl_lvl_o === '0 && rvalid_o === 0,
              "R1 reset state", {ready_o, pre_o, wl_o}, {2'b11, NR'(0)});
        rst_n = 1'b1;
        cyc(0, 0, '0, '0);                 // R1: first cycle after reset
        op(1, 4'd3, 8'hA5, 0);             // R2 R3 mixed word
        op(0, 4'd3, '0, 0);                // R4..R8
        op(0, 4'd3, '0, 0);                // R6 R8 restore kept word
        op(1, 4'd0, 8'h00, 1);             // R2 all zeros, R9 noise
        op(1, 4'd15, 8'hFF, 0);            // R11 top row
        op(0, 4'd15, '0, 1);               // R9 noise on read
        op(0, 4'd0, '0, 0);
        op(0, 4'd0, '0, 0);
        op(1, 4'd7, 8'h3C, 0);
        op(0, 4'd7, '0, 0);
        op(0, 4'd15, '0, 0);               // back-to-back in rvalid cycle
        cyc(0, 0, '0, '0);
        cyc(0, 0, '0, '0);
        // R6: array holds the written words after destructive reads
        for (int r = 0; r < NR; r++)
            check(cells[r] === ref_mem[r], "R6 cell contents", cells[r], ref_mem[r]);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule